// File: doc/BRIEF.md
# In-Order Pipeline Fetch Sequencer and Branch Controller

This block sequences instruction fetch for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It owns the program counter and the valid bits of the four stage registers that follow fetch: IF/ID, ID/EX, EX/MEM and MEM/WB. From these it produces the fetch address and the load, squash and bubble controls for those registers. The datapath keeps the instruction payloads. The datapath gates those registers with the signals produced here, and this block reports which stage slots hold live instructions.

Branches are resolved in decode. The block compares the two register operands read in decode for equality. In parallel it forms the target from the address of the instruction in fetch, which is the branch address plus 4, and the sign-extended offset scaled by 4. A run-time mode input picks the branch policy:
- **Freeze:** the slot fetched behind every branch is discarded, whatever the branch outcome.
- **Predict-not-taken:** sequential fetch continues, and only a taken branch discards the slot fetched behind it.

A stall request from decode holds the program counter and IF/ID, and it inserts an empty slot into ID/EX. The older stages keep draining.

Top module: `pipe_seq_ctrl`

## Requirements
- R1: A synchronous reset sets the fetch address to `RESET_VEC` (default 0x100) and clears all four stage valid bits. `stage_vld_o` is indexed bit0=ID, bit1=EX, bit2=MEM, bit3=WB.
- R2: With no stall and no branch, the fetch address rises by 4 on every clock edge. The valid bits shift one stage per edge, and decode becomes valid on the first edge after reset.
- R3: When decode is valid and `stall_req_i`=1, the following hold in that cycle: `pc_en_o`=0, `ifid_en_o`=0 and `idex_bubble_o`=1. On the next edge the fetch address and the ID valid bit keep their values, EX becomes invalid, and MEM and WB take the values of EX and MEM.
- R4: A stall request while decode is invalid has no effect. Fetch advances and no bubble is signalled.
- R5: A branch counts as taken only when all `DATA_W` bits of `rs_val_i` and `rt_val_i` are equal. Its target is the current fetch address plus `offset_i`×4, with `offset_i` a two's-complement value, so negative offsets go backwards.
- R6: With `mode_i`=0 (freeze), every branch that leaves decode raises `ifid_squash_o`. The next fetch address is the target if the branch is taken. Otherwise the next fetch address is the current fetch address, so the discarded slot is fetched again. This costs one lost writeback slot per branch.
- R7: With `mode_i`=1 (predict-not-taken), a branch that is not taken behaves like R2. A taken branch raises `ifid_squash_o` and redirects fetch to the target. This costs one lost writeback slot per taken branch only.
- R8: A branch is acted on only in the cycle in which it leaves decode. While a stall holds it, and whenever decode is invalid, `br_flag_i` causes no squash and no redirect.
- R9: A squashed slot is invalid in ID on the next edge. It then travels down as an invalid slot and never reaches WB as a valid instruction.
- R10: `ifid_squash_o` and `idex_bubble_o` are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Branch policy: 0 = freeze, 1 = predict-not-taken |
| stall_req_i | input | 1 | Stall request from decode |
| br_flag_i | input | 1 | Decode holds a branch |
| rs_val_i | input | DATA_W | First register operand read in decode |
| rt_val_i | input | DATA_W | Second register operand read in decode |
| offset_i | input | ADDR_W | Sign-extended branch offset in instruction words |
| fetch_addr_o | output | ADDR_W | Current fetch address |
| pc_en_o | output | 1 | Program counter loads this cycle |
| ifid_en_o | output | 1 | IF/ID register loads this cycle |
| ifid_squash_o | output | 1 | IF/ID loads an empty slot (wrong-path fetch) |
| idex_bubble_o | output | 1 | ID/EX loads an empty slot (stall) |
| stage_vld_o | output | 4 | Valid bits of ID, EX, MEM, WB (bit0 = ID) |

## Verification
A stall request and a branch can both reach decode in the same cycle. The bench provokes this by raising `stall_req_i` together with a taken `br_flag_i`. Stall must win: there is a bubble, no squash and a held fetch address. The redirect must then fire in the following cycle, once the stall is released while the branch is still presented. The bench also presents a branch to an empty decode slot and a stall to an empty decode slot right after reset. It counts lost writeback slots over runs of mixed taken and not-taken branches in both modes to confirm the per-branch penalties.

// File: rtl/pipe_seq_pkg.sv
`timescale 1ns/1ps
package pipe_seq_pkg;

    typedef enum logic {
        MODE_FREEZE = 1'b0,
        MODE_PNT    = 1'b1
    } br_mode_e;

    localparam int unsigned NUM_SLOT = 4;
    localparam int unsigned ID_IX    = 0;
    localparam int unsigned EX_IX    = 1;
    localparam int unsigned MEM_IX   = 2;
    localparam int unsigned WB_IX    = 3;

endpackage

// File: rtl/br_resolve.sv
`timescale 1ns/1ps
module br_resolve #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFF_SHFT = 2
) (
    input  logic [DATA_W-1:0] rs_i,
    input  logic [DATA_W-1:0] rt_i,
    input  logic [ADDR_W-1:0] offs_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    output logic              eq_o,
    output logic [ADDR_W-1:0] target_o
);
    // equality test on the operands read in decode
    assign eq_o     = (rs_i == rt_i);
    // seq_pc_i already equals branch address + one instruction
    assign target_o = seq_pc_i + (offs_i << OFF_SHFT);
endmodule

// File: rtl/flow_ctrl.sv
`timescale 1ns/1ps
module flow_ctrl
    import pipe_seq_pkg::*;
(
    input  br_mode_e mode_i,
    input  logic     id_vld_i,
    input  logic     stall_req_i,
    input  logic     br_flag_i,
    input  logic     br_eq_i,
    output logic     stall_o,
    output logic     squash_o,
    output logic     take_o,
    output logic     refetch_o
);
    logic br_go;

    always_comb begin
        stall_o   = id_vld_i & stall_req_i;
        // a branch acts only when it actually leaves decode
        br_go     = id_vld_i & br_flag_i & ~stall_o;
        take_o    = br_go & br_eq_i;
        squash_o  = 1'b0;
        refetch_o = 1'b0;
        unique case (mode_i)
            MODE_FREEZE: begin
                squash_o  = br_go;
                refetch_o = br_go & ~br_eq_i;
            end
            MODE_PNT: begin
                squash_o  = br_go & br_eq_i;
            end
            default: begin
                squash_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pc_next.sv
`timescale 1ns/1ps
module pc_next #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              stall_i,
    input  logic              take_i,
    input  logic              refetch_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] pc_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    assign seq_o = pc_i + STEP;

    always_comb begin
        if (stall_i || refetch_i) begin
            pc_o = pc_i;
        end else if (take_i) begin
            pc_o = target_i;
        end else begin
            pc_o = seq_o;
        end
    end
endmodule

// File: rtl/pipe_seq_ctrl.sv
`timescale 1ns/1ps
module pipe_seq_ctrl
    import pipe_seq_pkg::*;
#(
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 'h100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_i,
    input  logic                stall_req_i,
    input  logic                br_flag_i,
    input  logic [DATA_W-1:0]   rs_val_i,
    input  logic [DATA_W-1:0]   rt_val_i,
    input  logic [ADDR_W-1:0]   offset_i,
    output logic [ADDR_W-1:0]   fetch_addr_o,
    output logic                pc_en_o,
    output logic                ifid_en_o,
    output logic                ifid_squash_o,
    output logic                idex_bubble_o,
    output logic [NUM_SLOT-1:0] stage_vld_o
);
    localparam int unsigned OFF_SHFT = $clog2(INSTR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0]   pc;
        logic [NUM_SLOT-1:0] vld;
    } seq_st_t;

    seq_st_t st_q, st_d;

    logic              br_eq, stall, squash, take, refetch;
    logic [ADDR_W-1:0] target, seq_pc, pc_nx;

    br_resolve #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .OFF_SHFT(OFF_SHFT)
    ) u_br (
        .rs_i    (rs_val_i),
        .rt_i    (rt_val_i),
        .offs_i  (offset_i),
        .seq_pc_i(st_q.pc),
        .eq_o    (br_eq),
        .target_o(target)
    );

    flow_ctrl u_flow (
        .mode_i     (br_mode_e'(mode_i)),
        .id_vld_i   (st_q.vld[ID_IX]),
        .stall_req_i(stall_req_i),
        .br_flag_i  (br_flag_i),
        .br_eq_i    (br_eq),
        .stall_o    (stall),
        .squash_o   (squash),
        .take_o     (take),
        .refetch_o  (refetch)
    );

    pc_next #(
        .ADDR_W     (ADDR_W),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_pc (
        .pc_i     (st_q.pc),
        .target_i (target),
        .stall_i  (stall),
        .take_i   (take),
        .refetch_i(refetch),
        .seq_o    (seq_pc),
        .pc_o     (pc_nx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nx;
        if (stall) begin
            st_d.vld[ID_IX] = st_q.vld[ID_IX];
            st_d.vld[EX_IX] = 1'b0;
        end else begin
            st_d.vld[ID_IX] = ~squash;
            st_d.vld[EX_IX] = st_q.vld[ID_IX];
        end
        // older stages never hold
        for (int i = MEM_IX; i < NUM_SLOT; i++) begin
            st_d.vld[i] = st_q.vld[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc  <= RESET_VEC;
            st_q.vld <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o  = st_q.pc;
    assign pc_en_o       = ~stall;
    assign ifid_en_o     = ~stall;
    assign ifid_squash_o = squash;
    assign idex_bubble_o = stall;
    assign stage_vld_o   = st_q.vld;

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (fetch_addr_o == RESET_VEC && stage_vld_o == '0));

    // R2: plain flow advances by one instruction
    a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
        (!idex_bubble_o && !ifid_squash_o) |=>
            fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(INSTR_BYTES));

    // R3: stall holds fetch and empties EX
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
        idex_bubble_o |=> $stable(fetch_addr_o));
    a_r3_ex_bubble: assert property (@(posedge clk) disable iff (rst)
        idex_bubble_o |=> !stage_vld_o[EX_IX]);

    // R6: freeze mode discards behind every departing branch
    a_r6_freeze_squash: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 1'b0 && stage_vld_o[ID_IX] && br_flag_i && !stall_req_i)
            |-> ifid_squash_o);

    // R8: a held branch never redirects
    a_r8_held_branch: assert property (@(posedge clk) disable iff (rst)
        (stage_vld_o[ID_IX] && stall_req_i) |-> !ifid_squash_o);

    // R9: squashed slot enters decode empty
    a_r9_squash_kills: assert property (@(posedge clk) disable iff (rst)
        ifid_squash_o |=> !stage_vld_o[ID_IX]);

    // R10: squash and bubble exclusive
    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        !(ifid_squash_o && idex_bubble_o));

endmodule

// File: tb/test_pipe_seq_ctrl.sv
`timescale 1ns/1ps
module test_pipe_seq_ctrl;
    localparam logic [31:0] RV = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b1;
    logic        stall = 1'b0;
    logic        brf = 1'b0;
    logic [31:0] rs = '0, rt = '0, off = '0;
    logic [31:0] fa;
    logic        pc_en, ifid_en, squash, bubble;
    logic [3:0]  vld;

    int total = 0;
    int bad   = 0;
    int lost  = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pipe_seq_ctrl i_pipe_seq_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode), .stall_req_i(stall),
        .br_flag_i(brf), .rs_val_i(rs), .rt_val_i(rt), .offset_i(off),
        .fetch_addr_o(fa), .pc_en_o(pc_en), .ifid_en_o(ifid_en),
        .ifid_squash_o(squash), .idex_bubble_o(bubble), .stage_vld_o(vld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (!vld[3]) lost++;
    endtask

    task automatic idle();
        stall = 0; brf = 0; rs = 0; rt = 1; off = 0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    task automatic fill();
        do_reset();
        repeat (4) tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 fetch addr", fa, RV);
        chk("R1 valid bits", {28'd0, vld}, 32'd0);
    endtask

    task automatic t_flow();
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk("R2 seq fetch", fa, RV + 32'(4 * k));
            chk("R2 valid shift", {28'd0, vld}, (k >= 4) ? 32'hF : ((32'd1 << k) - 1));
        end
    endtask

    task automatic t_stall();
        logic [31:0] p;
        fill();
        p = fa;
        stall = 1;
        #1;
        chk("R3 pc_en", {31'd0, pc_en}, 0);
        chk("R3 ifid_en", {31'd0, ifid_en}, 0);
        chk("R3 bubble", {31'd0, bubble}, 1);
        tick();
        chk("R3 pc held", fa, p);
        chk("R3 vld after stall", {28'd0, vld}, 32'hD);
        stall = 0;
        tick();
        chk("R3 resume", fa, p + 4);
        chk("R3 bubble drains 1", {28'd0, vld}, 32'hB);
        tick();
        chk("R3 bubble drains 2", {28'd0, vld}, 32'h7);
        tick();
        chk("R3 refilled", {28'd0, vld}, 32'hF);
    endtask

    task automatic t_stall_empty();
        do_reset();
        stall = 1;
        #1;
        chk("R4 no bubble", {31'd0, bubble}, 0);
        chk("R4 pc_en", {31'd0, pc_en}, 1);
        tick();
        chk("R4 fetch advances", fa, RV + 4);
        chk("R4 ID valid", {28'd0, vld}, 32'h1);
        stall = 0;
    endtask

    task automatic t_pnt_taken();
        logic [31:0] p;
        mode = 1;
        fill();
        p = fa;
        brf = 1; rs = 32'd7; rt = 32'd7; off = 32'd3;
        #1;
        chk("R7 squash taken", {31'd0, squash}, 1);
        tick();
        idle();
        chk("R5 target fwd", fa, p + 12);
        chk("R9 ID empty", {28'd0, vld}, 32'hE);
        tick();
        chk("R9 slot in EX", {28'd0, vld}, 32'hD);
        tick();
        chk("R9 slot in MEM", {28'd0, vld}, 32'hB);
        tick();
        chk("R9 slot at WB invalid", {28'd0, vld}, 32'h7);
        fill();
        p = fa;
        brf = 1; rs = 32'h55; rt = 32'h55; off = 32'hFFFF_FFFE;
        tick();
        idle();
        chk("R5 target backward", fa, p - 8);
    endtask

    task automatic t_pnt_not_taken();
        logic [31:0] p;
        mode = 1;
        fill();
        p = fa;
        brf = 1; rs = 32'h8000_0001; rt = 32'h0000_0001; off = 32'd9;
        #1;
        chk("R5 full-width compare no squash", {31'd0, squash}, 0);
        tick();
        idle();
        chk("R7 not taken sequential", fa, p + 4);
        chk("R7 not taken keeps ID", {28'd0, vld}, 32'hF);
    endtask

    task automatic t_freeze();
        logic [31:0] p;
        mode = 0;
        fill();
        p = fa;
        brf = 1; rs = 32'd1; rt = 32'd2; off = 32'd5;
        #1;
        chk("R6 squash not taken", {31'd0, squash}, 1);
        tick();
        idle();
        chk("R6 refetch", fa, p);
        chk("R6 ID empty", {28'd0, vld}, 32'hE);
        tick();
        chk("R6 continue", fa, p + 4);
        fill();
        p = fa;
        brf = 1; rs = 32'd4; rt = 32'd4; off = 32'd5;
        tick();
        idle();
        chk("R6 taken target", fa, p + 20);
    endtask

    task automatic t_stall_branch();
        logic [31:0] p;
        mode = 1;
        fill();
        p = fa;
        brf = 1; rs = 32'd3; rt = 32'd3; off = 32'd2; stall = 1;
        #1;
        chk("R8 no squash under stall", {31'd0, squash}, 0);
        chk("R10 bubble only", {31'd0, bubble & squash}, 0);
        tick();
        chk("R8 held fetch", fa, p);
        stall = 0;
        #1;
        chk("R8 squash on leave", {31'd0, squash}, 1);
        tick();
        idle();
        chk("R8 redirect after stall", fa, p + 8);
        chk("R8 vld pattern", {28'd0, vld}, 32'hA);
    endtask

    task automatic t_br_empty();
        mode = 1;
        do_reset();
        brf = 1; rs = 32'd6; rt = 32'd6; off = 32'd8;
        #1;
        chk("R8 empty ID no squash", {31'd0, squash}, 0);
        tick();
        idle();
        chk("R8 empty ID no redirect", fa, RV + 4);
    endtask

    task automatic t_penalty(input logic m);
        mode = m;
        fill();
        lost = 0;
        for (int i = 0; i < 4; i++) begin
            brf = 1; rs = 32'd1; rt = (i % 2 == 0) ? 32'd1 : 32'd0; off = 32'd1;
            tick();
            idle();
            tick();
            tick();
        end
        repeat (4) tick();
        if (m) chk("R7 lost slots per taken branch", lost, 2);
        else   chk("R6 lost slots per branch", lost, 4);
    endtask

    initial begin
        t_reset();
        t_flow();
        t_stall();
        t_stall_empty();
        t_pnt_taken();
        t_pnt_not_taken();
        t_freeze();
        t_stall_branch();
        t_br_empty();
        t_penalty(1'b0);
        t_penalty(1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule